// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register file and protocol sequencer of a parallel ATA drive. A host reaches it over a 3-bit command-block address, plus a select line that switches to the control block. Several addresses hold one register for reads and a different one for writes. The block keeps the sector address and count registers, the drive/head byte, the status byte and the device-control settings. It works out which of two devices on the cable is addressed, and it forms a 28-bit logical block address from four registers.

A command byte written while the device is idle starts one of four command sequences: PIO data-in, PIO data-out, DMA, or a command with no data. The media and the DMA engine stay outside the block. They report through two strobes: `xfer_rdy_i` says a sector buffer or the DMA engine is ready, and `xfer_done_i` says the command has finished. Each data protocol passes through a prepare phase with BSY set, then an interrupt-posting phase, then a transfer phase with DRQ set. Software reset, interrupt masking and interrupt clearing on a status read follow the usual task-file rules.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x50 (DRDY 0x40 | SEEK 0x10), `intrq_o` is low, device 0 is selected and the sector count reads 0.
- R2: With `ctl_sel_i`=0, addresses 2..6 (sector count, sector number, cylinder low, cylinder high, drive/head) read back the byte last written. Address 1 reads the error byte, which is 0x00. A write to address 1 sets the features byte shown on `feat_o`.
- R3: `lba_o` = {drive/head[3:0], cylinder high, cylinder low, sector number}, and `lba_mode_o` is drive/head bit 6.
- R4: `sec_total_o` equals the sector count when that count is 1..128. It is 128 when the count is 0 or above 128.
- R5: Drive/head bit 4 selects device 1 when set and device 0 when clear. The block answers as device `DEV_ID`. While it is not selected, every read returns 0 and every command-block write other than drive/head is ignored.
- R6: While BSY (status bit 7) is set, command-block writes are ignored. Device-control writes (`ctl_sel_i`=1, address 2) are always taken.
- R7: A command byte (address 7) written while idle pulses `cmd_start_o` once and shows the code on `cmd_o`. A code other than 0x20, 0x30, 0xC8 or 0xCA holds status at 0x80 until `xfer_done_i`. Status then becomes exactly 0x50, with BSY, DRQ and DF cleared, and an interrupt is posted.
- R8: Code 0x20 (PIO in) holds status at 0x80 until `xfer_rdy_i`. Status then becomes 0x58 (DRQ 0x08 added) and an interrupt is posted. Each data read (address 0) returns `media_rdata_i` and pulses `pio_rd_o`. After `WORDS_PER_SEC` reads, a sector that is not the last returns status to 0x80 to wait again. The last sector sets status to 0x50 without posting a new interrupt.
- R9: Code 0x30 (PIO out) prepares and posts an interrupt in the same way. Each data write pulses `pio_wr_o` and passes the written word on `pio_wdata_o`. After the last sector, status stays 0x80 until `xfer_done_i`. It then becomes 0x50 and an interrupt is posted.
- R10: Codes 0xC8 and 0xCA (DMA) hold status at 0x80 until `xfer_rdy_i`. Status then reads 0x88 and `dma_go_o` is high until `xfer_done_i`. Status then becomes 0x50 and an interrupt is posted.
- R11: `intrq_o` is the pending interrupt masked by nIEN, which is device-control bit 1. A status read (address 7) clears the pending interrupt. An alternate-status read (`ctl_sel_i`=1, address 2) does not clear it.
- R12: Setting device-control bit 2 abandons any command, forces status to 0x80 and clears the pending interrupt. Clearing the bit returns the device to idle with status 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_sel_i | input | 1 | 1 selects the control block, 0 the command block |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DATA_W | Write data; byte registers use bits 7:0 |
| rdata_o | output | DATA_W | Read data for the addressed register |
| intrq_o | output | 1 | Interrupt request to the host |
| cmd_start_o | output | 1 | One-cycle pulse when a command is accepted |
| cmd_o | output | 8 | Last accepted command code |
| feat_o | output | 8 | Features byte |
| lba_o | output | 28 | Assembled logical block address |
| lba_mode_o | output | 1 | LBA addressing selected |
| sec_total_o | output | 8 | Sectors in the transfer, 1..MAX_SECS |
| xfer_rdy_i | input | 1 | Media or DMA engine ready for the next phase |
| xfer_done_i | input | 1 | Media or DMA engine finished the command |
| dma_go_o | output | 1 | DMA transfer phase active |
| pio_rd_o | output | 1 | Host is reading a PIO data word |
| pio_wr_o | output | 1 | Host is writing a PIO data word |
| pio_wdata_o | output | DATA_W | PIO word written by the host |
| media_rdata_i | input | DATA_W | PIO word supplied by the media |

## Verification
The hardest state to reach from the ports is the point where the last PIO-in sector ends. To check it, the bench has to show that the final read sets status to 0x50 without a new interrupt, even though the interrupt from that block's start is still pending. The bench runs a two-sector read with a short sector. It clears the earlier interrupt with a status read between sectors, then reads status after the final word and watches `intrq_o` stay low. A software reset sent while a command is busy and an interrupt is pending is the other reachable corner. The bench builds it by leaving the DMA completion interrupt unread before it starts a new command.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SRST, ST_EXEC,
    ST_PIN_PREP, ST_PIN_INTR, ST_PIN_XFER,
    ST_POUT_PREP, ST_POUT_INTR, ST_POUT_XFER,
    ST_DMA_PREP, ST_DMA_XFER
  } dev_state_e;

  typedef enum logic [1:0] {CK_NODATA, CK_PIN, CK_POUT, CK_DMA} cmd_kind_e;

  localparam logic [7:0] STS_BSY  = 8'h80;
  localparam logic [7:0] STS_DONE = 8'h50;  // DRDY | SEEK
  localparam logic [7:0] STS_DRQ  = 8'h58;  // DRDY | SEEK | DRQ
  localparam logic [7:0] STS_DMA  = 8'h88;  // BSY | DRQ

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_ERR  = 3'd1;
  localparam logic [2:0] A_SC   = 3'd2;
  localparam logic [2:0] A_SN   = 3'd3;
  localparam logic [2:0] A_CL   = 3'd4;
  localparam logic [2:0] A_CH   = 3'd5;
  localparam logic [2:0] A_DH   = 3'd6;
  localparam logic [2:0] A_CMD  = 3'd7;
  localparam logic [2:0] A_CTL  = 3'd2;

  function automatic cmd_kind_e classify(input logic [7:0] code);
    case (code)
      8'h20:        classify = CK_PIN;
      8'h30:        classify = CK_POUT;
      8'hC8, 8'hCA: classify = CK_DMA;
      default:      classify = CK_NODATA;
    endcase
  endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int          MAX_SECS = 128,
  parameter logic        DEV_ID   = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        ctl_sel_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wbyte_i,
  input  logic        bsy_i,
  input  logic        idle_i,
  output logic        sel_o,
  output logic [7:0]  sc_o,
  output logic [7:0]  sn_o,
  output logic [7:0]  cl_o,
  output logic [7:0]  ch_o,
  output logic [7:0]  dh_o,
  output logic [7:0]  feat_o,
  output logic [7:0]  cmd_o,
  output logic        cmd_wr_o,
  output logic [27:0] lba_o,
  output logic        lba_mode_o,
  output logic [7:0]  sec_total_o
);

  localparam logic [7:0] MAX_B = 8'(MAX_SECS);

  logic wr_cb, wr_sel;

  assign sel_o    = (dh_o[4] == DEV_ID);
  assign wr_cb    = wr_i && !ctl_sel_i && !bsy_i;
  assign wr_sel   = wr_cb && sel_o;
  assign cmd_wr_o = wr_sel && (addr_i == A_CMD) && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_o <= '0; sn_o <= '0; cl_o <= '0; ch_o <= '0;
      dh_o <= '0; feat_o <= '0; cmd_o <= '0;
    end else begin
      if (wr_cb && addr_i == A_DH) dh_o <= wbyte_i;  // both devices latch
      if (wr_sel) begin
        case (addr_i)
          A_ERR: feat_o <= wbyte_i;
          A_SC:  sc_o   <= wbyte_i;
          A_SN:  sn_o   <= wbyte_i;
          A_CL:  cl_o   <= wbyte_i;
          A_CH:  ch_o   <= wbyte_i;
          default: ;
        endcase
      end
      if (cmd_wr_o) cmd_o <= wbyte_i;
    end
  end

  assign lba_o       = {dh_o[3:0], ch_o, cl_o, sn_o};
  assign lba_mode_o  = dh_o[6];
  assign sec_total_o = (sc_o == 8'd0 || sc_o > MAX_B) ? MAX_B : sc_o;

  a_r6_bsy_blocks_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_i && wr_i && !ctl_sel_i) |=> $stable({sc_o, sn_o, cl_o, ch_o, dh_o, feat_o}));

  a_r5_unsel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_o && wr_i && !ctl_sel_i && addr_i != A_DH) |=> $stable({sc_o, sn_o, cl_o, ch_o, feat_o, cmd_o}));

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       ctl_sel_i,
  input  logic [2:0] addr_i,
  input  logic       nien_d_i,
  input  logic       srst_d_i,
  input  logic       sel_i,
  input  logic       intr_set_i,
  output logic       srst_o,
  output logic       intrq_o
);

  logic nien_q, pend_q, ctl_wr, stat_rd;

  assign ctl_wr  = wr_i && ctl_sel_i && (addr_i == A_CTL);
  assign stat_rd = rd_i && !ctl_sel_i && (addr_i == A_CMD) && sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nien_q <= 1'b0;
      srst_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        nien_q <= nien_d_i;
        srst_o <= srst_d_i;
      end
      if (srst_o)          pend_q <= 1'b0;
      else if (intr_set_i) pend_q <= 1'b1;
      else if (stat_rd)    pend_q <= 1'b0;
    end
  end

  assign intrq_o = pend_q && !nien_q;

  a_r11_status_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !intr_set_i) |=> !pend_q);

  a_r12_srst_clears_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> !intrq_o);

endmodule

// File: rtl/ata_tf_fsm.sv
module ata_tf_fsm
  import ata_tf_pkg::*;
#(
  parameter int WORDS_PER_SEC = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] sec_total_i,
  input  logic       data_rd_i,
  input  logic       data_wr_i,
  input  logic       xfer_rdy_i,
  input  logic       xfer_done_i,
  output logic [7:0] status_o,
  output logic       idle_o,
  output logic       pin_xfer_o,
  output logic       intr_set_o,
  output logic       cmd_start_o,
  output logic       dma_go_o,
  output logic       pio_rd_o,
  output logic       pio_wr_o
);

  localparam int WCW = (WORDS_PER_SEC > 1) ? $clog2(WORDS_PER_SEC) : 1;
  localparam logic [WCW-1:0] LAST_W = WCW'(WORDS_PER_SEC - 1);

  dev_state_e      state_q;
  logic [WCW-1:0]  words_q;
  logic [7:0]      secs_q;
  logic            last_w, last_s;

  assign last_w     = (words_q == LAST_W);
  assign last_s     = (secs_q == 8'd1);
  assign idle_o     = (state_q == ST_IDLE);
  assign pin_xfer_o = (state_q == ST_PIN_XFER);
  assign dma_go_o   = (state_q == ST_DMA_XFER);
  assign pio_rd_o   = data_rd_i && (state_q == ST_PIN_XFER);
  assign pio_wr_o   = data_wr_i && (state_q == ST_POUT_XFER);

  always_comb begin
    intr_set_o = 1'b0;
    if (!srst_i) begin
      case (state_q)
        ST_PIN_INTR, ST_POUT_INTR: intr_set_o = 1'b1;
        ST_EXEC, ST_DMA_XFER:      intr_set_o = xfer_done_i;
        default:                   intr_set_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      status_o    <= STS_DONE;
      words_q     <= '0;
      secs_q      <= '0;
      cmd_start_o <= 1'b0;
    end else begin
      cmd_start_o <= 1'b0;
      if (srst_i) begin
        state_q  <= ST_SRST;
        status_o <= STS_BSY;
      end else begin
        case (state_q)
          ST_IDLE: if (cmd_wr_i) begin
            cmd_start_o <= 1'b1;
            secs_q      <= sec_total_i;
            words_q     <= '0;
            status_o    <= STS_BSY;
            case (classify(cmd_i))
              CK_PIN:  state_q <= ST_PIN_PREP;
              CK_POUT: state_q <= ST_POUT_PREP;
              CK_DMA:  state_q <= ST_DMA_PREP;
              default: state_q <= ST_EXEC;
            endcase
          end
          ST_SRST: begin
            state_q  <= ST_IDLE;
            status_o <= STS_DONE;
          end
          ST_EXEC, ST_DMA_XFER: if (xfer_done_i) begin
            state_q  <= ST_IDLE;
            status_o <= STS_DONE;
          end
          ST_PIN_PREP: if (xfer_rdy_i) begin
            state_q  <= ST_PIN_INTR;
            status_o <= STS_DRQ;
          end
          ST_POUT_PREP: if (xfer_rdy_i) begin
            state_q  <= ST_POUT_INTR;
            status_o <= STS_DRQ;
          end
          ST_DMA_PREP: if (xfer_rdy_i) begin
            state_q  <= ST_DMA_XFER;
            status_o <= STS_DMA;
          end
          ST_PIN_INTR:  state_q <= ST_PIN_XFER;
          ST_POUT_INTR: state_q <= ST_POUT_XFER;
          ST_PIN_XFER, ST_POUT_XFER: begin
            if ((state_q == ST_PIN_XFER) ? data_rd_i : data_wr_i) begin
              words_q <= words_q + WCW'(1);
              if (last_w) begin
                words_q <= '0;
                secs_q  <= secs_q - 8'd1;
                if (!last_s) begin
                  state_q  <= (state_q == ST_PIN_XFER) ? ST_PIN_PREP : ST_POUT_PREP;
                  status_o <= STS_BSY;
                end else if (state_q == ST_PIN_XFER) begin
                  state_q  <= ST_IDLE;
                  status_o <= STS_DONE;
                end else begin
                  state_q  <= ST_EXEC;  // wait for media flush
                  status_o <= STS_BSY;
                end
              end
            end
          end
          default: begin
            state_q  <= ST_IDLE;
            status_o <= STS_DONE;
          end
        endcase
      end
    end
  end

  a_r7_done_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && xfer_done_i && !srst_i) |=> (status_o == STS_DONE));

  a_r8_last_read_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PIN_XFER && data_rd_i && last_w && last_s && !srst_i)
      |=> (status_o == STS_DONE && !intr_set_o));

  a_r10_bsy_drq_only_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && status_o[3]) |-> dma_go_o);

  a_r12_srst_forces_bsy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (status_o == STS_BSY));

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int   DATA_W        = 16,
  parameter int   WORDS_PER_SEC = 256,
  parameter int   MAX_SECS      = 128,
  parameter logic DEV_ID        = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_sel_i,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              intrq_o,
  output logic              cmd_start_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        feat_o,
  output logic [27:0]       lba_o,
  output logic              lba_mode_o,
  output logic [7:0]        sec_total_o,
  input  logic              xfer_rdy_i,
  input  logic              xfer_done_i,
  output logic              dma_go_o,
  output logic              pio_rd_o,
  output logic              pio_wr_o,
  output logic [DATA_W-1:0] pio_wdata_o,
  input  logic [DATA_W-1:0] media_rdata_i
);

  localparam int PAD_W = DATA_W - 8;

  logic       sel, cmd_wr, idle, pin_xfer, intr_set, srst;
  logic       data_rd, data_wr;
  logic [7:0] sc, sn, cl, ch, dh, status, rbyte;

  assign data_rd     = rd_i && !ctl_sel_i && (addr_i == A_DATA) && sel;
  assign data_wr     = wr_i && !ctl_sel_i && (addr_i == A_DATA) && sel;
  assign pio_wdata_o = wdata_i;

  ata_tf_regs #(.MAX_SECS(MAX_SECS), .DEV_ID(DEV_ID)) u_regs (
    .clk_i, .rst_ni, .wr_i, .ctl_sel_i, .addr_i,
    .wbyte_i(wdata_i[7:0]), .bsy_i(status[7]), .idle_i(idle),
    .sel_o(sel), .sc_o(sc), .sn_o(sn), .cl_o(cl), .ch_o(ch), .dh_o(dh),
    .feat_o, .cmd_o, .cmd_wr_o(cmd_wr), .lba_o, .lba_mode_o, .sec_total_o
  );

  ata_tf_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rd_i, .ctl_sel_i, .addr_i,
    .nien_d_i(wdata_i[1]), .srst_d_i(wdata_i[2]), .sel_i(sel),
    .intr_set_i(intr_set), .srst_o(srst), .intrq_o
  );

  ata_tf_fsm #(.WORDS_PER_SEC(WORDS_PER_SEC)) u_fsm (
    .clk_i, .rst_ni, .srst_i(srst), .cmd_wr_i(cmd_wr), .cmd_i(wdata_i[7:0]),
    .sec_total_i(sec_total_o), .data_rd_i(data_rd), .data_wr_i(data_wr),
    .xfer_rdy_i, .xfer_done_i, .status_o(status), .idle_o(idle),
    .pin_xfer_o(pin_xfer), .intr_set_o(intr_set), .cmd_start_o,
    .dma_go_o, .pio_rd_o, .pio_wr_o
  );

  always_comb begin
    rbyte = 8'h00;
    if (ctl_sel_i) begin
      if (addr_i == A_CTL) rbyte = status;
    end else begin
      case (addr_i)
        A_SC:    rbyte = sc;
        A_SN:    rbyte = sn;
        A_CL:    rbyte = cl;
        A_CH:    rbyte = ch;
        A_DH:    rbyte = dh;
        A_CMD:   rbyte = status;
        default: rbyte = 8'h00;  // error byte stays clear
      endcase
    end
  end

  always_comb begin
    if (!sel)
      rdata_o = '0;
    else if (!ctl_sel_i && addr_i == A_DATA)
      rdata_o = pin_xfer ? media_rdata_i : '0;
    else
      rdata_o = {{PAD_W{1'b0}}, rbyte};
  end

  a_r5_unselected_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> (rdata_o == '0));

endmodule

// File: tb/tb_ata_taskfile.sv
module tb_ata_taskfile;

  localparam int WORDS = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_sel = 0, wr = 0, rd = 0, xfer_rdy = 0, xfer_done = 0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pio_wdata, media_rdata = '0;
  logic        intrq, cmd_start, lba_mode, dma_go, pio_rd, pio_wr;
  logic [7:0]  cmd, feat, sec_total;
  logic [27:0] lba;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic        start_seen, pwr_seen;
  logic [15:0] pwd_seen, v;
  logic        p;

  always #10 clk = ~clk;

  ata_taskfile #(.DATA_W(16), .WORDS_PER_SEC(WORDS), .MAX_SECS(128), .DEV_ID(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_sel_i(ctl_sel), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .intrq_o(intrq), .cmd_start_o(cmd_start), .cmd_o(cmd),
    .feat_o(feat), .lba_o(lba), .lba_mode_o(lba_mode), .sec_total_o(sec_total),
    .xfer_rdy_i(xfer_rdy), .xfer_done_i(xfer_done), .dma_go_o(dma_go), .pio_rd_o(pio_rd),
    .pio_wr_o(pio_wr), .pio_wdata_o(pio_wdata), .media_rdata_i(media_rdata)
  );

  // {addr, write byte, expected read}
  localparam logic [18:0] TBL [0:5] = '{
    {3'd2, 8'h05, 8'h05}, {3'd3, 8'h78, 8'h78}, {3'd4, 8'h56, 8'h56},
    {3'd5, 8'h34, 8'h34}, {3'd6, 8'h4C, 8'h4C}, {3'd1, 8'h3C, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic c, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    ctl_sel = c; addr = a; wdata = d; wr = 1;
    #1 pwr_seen = pio_wr; pwd_seen = pio_wdata;
    @(posedge clk);
    #1 start_seen = cmd_start; wr = 0;
  endtask

  task automatic rd_reg(input logic c, input logic [2:0] a, output logic [15:0] val, output logic pr);
    @(negedge clk);
    ctl_sel = c; addr = a; rd = 1;
    #1 val = rdata; pr = pio_rd;
    @(posedge clk);
    #1 rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rdy();
    @(negedge clk); xfer_rdy = 1;
    @(negedge clk); xfer_rdy = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd_reg(0, 3'd7, v, p); check("R1 status", v, 16'h0050);
    check("R1 intrq", intrq, 0);
    rd_reg(0, 3'd2, v, p); check("R1 sector count", v, 16'h0000);

    // R2 register offsets through the vector table
    for (int i = 0; i < 6; i++) begin
      wr_reg(0, TBL[i][18:16], {8'h00, TBL[i][15:8]});
      rd_reg(0, TBL[i][18:16], v, p);
      check("R2 readback", v, {8'h00, TBL[i][7:0]});
    end
    check("R2 features", feat, 8'h3C);
    check("R3 lba", lba, 28'hC345678);
    check("R3 lba mode", lba_mode, 1);
    check("R4 count 5", sec_total, 8'd5);

    // R4 count clamping
    wr_reg(0, 3'd2, 16'h0000); check("R4 count 0", sec_total, 8'd128);
    wr_reg(0, 3'd2, 16'h00C8); check("R4 count 200", sec_total, 8'd128);
    wr_reg(0, 3'd2, 16'h0080); check("R4 count 128", sec_total, 8'd128);
    wr_reg(0, 3'd2, 16'h0001); check("R4 count 1", sec_total, 8'd1);

    // R5 device selection
    wr_reg(0, 3'd6, 16'h0010);
    rd_reg(0, 3'd7, v, p); check("R5 unselected status", v, 16'h0000);
    rd_reg(0, 3'd2, v, p); check("R5 unselected count", v, 16'h0000);
    wr_reg(0, 3'd2, 16'h0022);
    wr_reg(0, 3'd6, 16'h0000);
    rd_reg(0, 3'd2, v, p); check("R5 write ignored", v, 16'h0001);

    // R7 non-data command, R6 write during BSY
    wr_reg(0, 3'd7, 16'h0090);
    check("R7 start pulse", start_seen, 1);
    check("R7 code", cmd, 8'h90);
    rd_reg(0, 3'd7, v, p); check("R7 busy", v, 16'h0080);
    wr_reg(0, 3'd2, 16'h0033);
    pulse_done(); idle(1);
    check("R7 interrupt", intrq, 1);
    rd_reg(1, 3'd2, v, p); check("R7 done status", v, 16'h0050);
    check("R11 alt read keeps irq", intrq, 1);
    rd_reg(0, 3'd2, v, p); check("R6 busy write ignored", v, 16'h0001);
    wr_reg(1, 3'd2, 16'h0002); idle(2);
    check("R11 nIEN masks", intrq, 0);
    wr_reg(1, 3'd2, 16'h0000); idle(2);
    check("R11 unmask", intrq, 1);
    rd_reg(0, 3'd7, v, p); check("R11 status", v, 16'h0050);
    check("R11 status read clears", intrq, 0);

    // R8 PIO in, two sectors
    wr_reg(0, 3'd2, 16'h0002);
    wr_reg(0, 3'd7, 16'h0020);
    rd_reg(0, 3'd7, v, p); check("R8 prepare busy", v, 16'h0080);
    pulse_rdy(); idle(2);
    check("R8 interrupt block0", intrq, 1);
    for (int b = 0; b < 2; b++) begin
      if (b == 1) begin
        rd_reg(0, 3'd7, v, p); check("R8 between sectors", v, 16'h0080);
        pulse_rdy(); idle(2);
        check("R8 interrupt block1", intrq, 1);
        rd_reg(1, 3'd2, v, p); check("R8 drq status", v, 16'h0058);
      end
      for (int w = 0; w < WORDS; w++) begin
        media_rdata = 16'hA000 + 16'(b * 16 + w);
        rd_reg(0, 3'd0, v, p);
        check("R8 data word", v, 16'hA000 + 16'(b * 16 + w));
        check("R8 read strobe", p, 1);
      end
    end
    rd_reg(0, 3'd7, v, p); check("R8 final status", v, 16'h0050);
    idle(3);
    check("R8 no final interrupt", intrq, 0);

    // R9 PIO out, one sector
    wr_reg(0, 3'd2, 16'h0001);
    wr_reg(0, 3'd7, 16'h0030);
    rd_reg(0, 3'd7, v, p); check("R9 prepare busy", v, 16'h0080);
    pulse_rdy(); idle(2);
    rd_reg(0, 3'd7, v, p); check("R9 drq status", v, 16'h0058);
    for (int w = 0; w < WORDS; w++) begin
      wr_reg(0, 3'd0, 16'hB000 + 16'(w));
      check("R9 write strobe", pwr_seen, 1);
      check("R9 write word", pwd_seen, 16'hB000 + 16'(w));
    end
    rd_reg(0, 3'd7, v, p); check("R9 flush busy", v, 16'h0080);
    pulse_done(); idle(1);
    check("R9 interrupt", intrq, 1);
    rd_reg(0, 3'd7, v, p); check("R9 done status", v, 16'h0050);

    // R10 DMA
    wr_reg(0, 3'd7, 16'h00C8);
    rd_reg(0, 3'd7, v, p); check("R10 prepare busy", v, 16'h0080);
    check("R10 no go yet", dma_go, 0);
    pulse_rdy(); idle(1);
    rd_reg(0, 3'd7, v, p); check("R10 transfer status", v, 16'h0088);
    check("R10 go", dma_go, 1);
    pulse_done(); idle(1);
    check("R10 go dropped", dma_go, 0);
    check("R10 interrupt", intrq, 1);
    rd_reg(1, 3'd2, v, p); check("R10 done status", v, 16'h0050);

    // R12 software reset during a busy command, R6 control write while busy
    wr_reg(0, 3'd7, 16'h0090);
    rd_reg(1, 3'd2, v, p); check("R12 busy before reset", v, 16'h0080);
    wr_reg(1, 3'd2, 16'h0004); idle(2);
    check("R12 pending cleared", intrq, 0);
    rd_reg(1, 3'd2, v, p); check("R12 reset status", v, 16'h0080);
    wr_reg(1, 3'd2, 16'h0000); idle(2);
    rd_reg(1, 3'd2, v, p); check("R6 R12 back to idle", v, 16'h0050);
    pulse_done(); idle(2);
    check("R12 command abandoned", intrq, 0);

    report();
  end

endmodule